// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing control for a successive-approximation converter. It divides the system clock down to a converter clock with a selectable prescaler. On the rising edges of that clock it steps a conversion counter. It produces a one-cycle sample-and-hold strobe and latches the channel select for the analog side. When a conversion ends, it loads the converter's 10-bit value into a result register and raises a completion flag.

Software sets the start bit by pulsing `start_set_i`. Conversions begin only on a converter clock rising edge. The first conversion after each enable is a longer, extended one, and later conversions are normal until enable is cleared and set again. In single mode the start bit drops when a conversion completes. In free-running mode it stays high and the next conversion starts at once. Clearing enable stops the prescaler and aborts any conversion in progress.

Top module: `adc_seq`

## Requirements
- R1: With enable high, `ps_sel_i` codes 0,1,2,3,4,5,6,7 make `adc_clk_o` a square wave with a period of 2,2,4,8,16,32,64,128 system cycles. After enable rises, `adc_clk_o` first goes high at the end of the first full division period.
- R2: While `en_i` is low, the prescaler is held at zero and `adc_clk_o` is low. The start bit is cleared, and any conversion in progress is aborted without changing `result_o` or setting `flag_o`.
- R3: A conversion begins on the first converter clock rising edge after the start bit is seen set. A normal conversion completes on the 13th rising edge after the one that began it.
- R4: The first conversion after `en_i` goes from low to high is extended and completes 25 converter clock cycles after it begins. Every later conversion is normal until enable is cleared again.
- R5: `sample_o` is high for one system cycle, in the cycle where `adc_clk_o` first reads low. This happens at the falling edge within converter cycle 2 of a normal conversion, or within cycle 14 of an extended conversion.
- R6: At completion, `result_o` takes the value of `conv_val_i` present at that edge, and `flag_o` rises in the same cycle as `adc_clk_o`.
- R7: In single mode (`free_run_i` = 0), `start_o` reads low in the cycle after completion, and no further conversion starts until the start bit is set again.
- R8: In free-running mode (`free_run_i` = 1), `start_o` stays high through each completion, and the next conversion begins on that same edge.
- R9: `ch_o` takes `ch_sel_i` when each conversion begins and holds it for the whole conversion.
- R10: `flag_o` stays high until a cycle with `flag_clr_i` or `irq_ack_i` high. A completion in that same cycle keeps it high.
- R11: A `start_set_i` pulse while `en_i` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| start_set_i | input | 1 | One-cycle pulse that sets the start bit |
| free_run_i | input | 1 | 1 = free-running, 0 = single conversion |
| ps_sel_i | input | 3 | Prescaler divide code |
| ch_sel_i | input | 3 | Channel select for the next conversion |
| conv_val_i | input | 10 | Value from the external converter |
| flag_clr_i | input | 1 | Write-one clear of the completion flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| adc_clk_o | output | 1 | Derived converter clock |
| sample_o | output | 1 | Sample-and-hold strobe |
| ch_o | output | 3 | Channel latched for the current conversion |
| result_o | output | 10 | Conversion result register |
| flag_o | output | 1 | Completion flag |
| start_o | output | 1 | Live state of the start bit |

## Verification
An off-by-one in the conversion counter moves the `flag_o` rise and the `result_o` load by one full converter period. It also moves the sample strobe by one falling edge, so the error shows at the first completion. A stale extended-conversion marker changes the next conversion's length by twelve converter cycles. A prescaler that keeps counting while disabled shifts the phase of `adc_clk_o` within one division period of re-enable. A wrong start-bit update shows on `start_o` in the cycle after completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NORM_LEN  = 13;
  localparam int EXT_LEN   = 25;
  localparam int NORM_SAMP = 2;
  localparam int EXT_SAMP  = 14;
  localparam int CYC_W     = $clog2(EXT_LEN + 1);
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PS_W = 3,
  localparam int CNT_W = (1 << PS_W) - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] ps_sel_i,
  output logic            rise_o,
  output logic            fall_o,
  output logic            adc_clk_o
);
  logic [CNT_W-1:0] cnt_q, mask, half, phase;
  logic [PS_W-1:0]  shamt;
  logic [CNT_W:0]   span;

  always_comb begin
    shamt = (ps_sel_i == '0) ? PS_W'(1) : ps_sel_i;
    span  = (CNT_W+1)'(1) << shamt;
    mask  = CNT_W'(span - 1'b1);
    half  = mask >> 1;
    phase = cnt_q & mask;
    rise_o = en_i && (phase == mask);
    fall_o = en_i && (phase == half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      adc_clk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      adc_clk_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (rise_o)      adc_clk_o <= 1'b1;
      else if (fall_o) adc_clk_o <= 1'b0;
    end
  end

  p_clk_low_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !adc_clk_o);
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            start_set_i,
  input  logic            free_run_i,
  input  logic [CH_W-1:0] ch_sel_i,
  input  logic            rise_i,
  input  logic            fall_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            sample_o,
  output logic [CH_W-1:0] ch_o,
  output logic            start_o
);
  logic [CYC_W-1:0] cyc_q, len, samp_pt;
  logic             long_q, ext_pend_q, last, launch;

  always_comb begin
    len     = long_q ? CYC_W'(EXT_LEN)  : CYC_W'(NORM_LEN);
    samp_pt = long_q ? CYC_W'(EXT_SAMP) : CYC_W'(NORM_SAMP);
    last    = busy_o && (cyc_q == len);
    done_o  = rise_i && last;
    launch  = rise_i && start_o && (!busy_o || (done_o && free_run_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o    <= 1'b0;
      busy_o     <= 1'b0;
      cyc_q      <= '0;
      long_q     <= 1'b0;
      ext_pend_q <= 1'b1;
      sample_o   <= 1'b0;
      ch_o       <= '0;
    end else if (!en_i) begin
      start_o    <= 1'b0;
      busy_o     <= 1'b0;
      cyc_q      <= '0;
      long_q     <= 1'b0;
      ext_pend_q <= 1'b1;
      sample_o   <= 1'b0;
    end else begin
      start_o  <= start_set_i | (start_o & ~(done_o & ~free_run_i));
      sample_o <= fall_i && busy_o && (cyc_q == samp_pt);
      if (launch) begin
        busy_o     <= 1'b1;
        cyc_q      <= CYC_W'(1);
        long_q     <= ext_pend_q;
        ext_pend_q <= 1'b0;
        ch_o       <= ch_sel_i;
      end else if (done_o) begin
        busy_o <= 1'b0;
        cyc_q  <= '0;
      end else if (rise_i && busy_o) begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  p_cyc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cyc_q >= CYC_W'(1) && cyc_q <= CYC_W'(EXT_LEN)));
  p_samp_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(busy_o));
  p_launch_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> $past(rise_i));
endmodule

// File: rtl/adc_result.sv
module adc_result #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [RES_W-1:0] conv_val_i,
  input  logic             flag_clr_i,
  input  logic             irq_ack_i,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flag_o   <= 1'b0;
    end else begin
      if (done_i) result_o <= conv_val_i;
      flag_o <= done_i | (flag_o & ~(flag_clr_i | irq_ack_i));
    end
  end

  p_flag_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i && !irq_ack_i) |=> flag_o);
  p_result_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(result_o));
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int PS_W  = 3,
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_set_i,
  input  logic             free_run_i,
  input  logic [PS_W-1:0]  ps_sel_i,
  input  logic [CH_W-1:0]  ch_sel_i,
  input  logic [RES_W-1:0] conv_val_i,
  input  logic             flag_clr_i,
  input  logic             irq_ack_i,
  output logic             adc_clk_o,
  output logic             sample_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o,
  output logic             start_o
);
  logic rise, fall, busy, done;

  adc_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i, .rst_ni, .en_i, .ps_sel_i,
    .rise_o(rise), .fall_o(fall), .adc_clk_o
  );

  adc_conv_fsm #(.CH_W(CH_W)) u_fsm (
    .clk_i, .rst_ni, .en_i, .start_set_i, .free_run_i, .ch_sel_i,
    .rise_i(rise), .fall_i(fall),
    .busy_o(busy), .done_o(done), .sample_o, .ch_o, .start_o
  );

  adc_result #(.RES_W(RES_W)) u_res (
    .clk_i, .rst_ni, .done_i(done), .conv_val_i, .flag_clr_i, .irq_ack_i,
    .result_o, .flag_o
  );

  p_samp_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (!adc_clk_o && $past(adc_clk_o)));
  p_done_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (flag_o && adc_clk_o));
  p_single_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !free_run_i && !start_set_i) |=> !start_o);
  p_free_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && free_run_i && en_i) |=> (start_o && busy));
  p_off_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!start_o && !busy && !sample_o));
endmodule

// File: tb/tb_adc_seq.sv
`timescale 1ns/1ps
module tb_adc_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 0, start_set = 0, free_run = 0, flag_clr = 0, irq_ack = 0;
  logic [2:0] ps_sel = 0, ch_sel = 0;
  logic [9:0] conv_v = 0;
  logic       adc_clk, sample, flag, start;
  logic [2:0] ch;
  logic [9:0] result;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_set_i(start_set),
    .free_run_i(free_run), .ps_sel_i(ps_sel), .ch_sel_i(ch_sel),
    .conv_val_i(conv_v), .flag_clr_i(flag_clr), .irq_ack_i(irq_ack),
    .adc_clk_o(adc_clk), .sample_o(sample), .ch_o(ch), .result_o(result),
    .flag_o(flag), .start_o(start)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_cnt, m_cyc, m_len, m_ch, m_res;
  bit  m_clk, m_samp, m_busy, m_ext, m_sc, m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cyc = 0; m_len = 13; m_ch = 0; m_res = 0;
      m_clk = 0; m_samp = 0; m_busy = 0; m_ext = 1; m_sc = 0; m_flag = 0;
    end else begin
      int div, ph;
      bit rise, fall, done, launch, nsc;
      div  = (ps_sel < 2) ? 2 : (1 << ps_sel);
      ph   = m_cnt % div;
      rise = en && (ph == div - 1);
      fall = en && (ph == div / 2 - 1);
      done = rise && m_busy && (m_cyc == m_len);
      launch = rise && m_sc && (!m_busy || (done && free_run));
      m_flag = done || (m_flag && !(flag_clr || irq_ack));
      if (done) m_res = conv_v;
      if (!en) begin
        m_cnt = 0; m_clk = 0; m_busy = 0; m_cyc = 0; m_sc = 0; m_ext = 1; m_samp = 0;
      end else begin
        m_samp = fall && m_busy && (m_cyc == ((m_len == 25) ? 14 : 2));
        nsc = start_set || (m_sc && !(done && !free_run));
        if (launch) begin
          m_busy = 1; m_cyc = 1; m_len = m_ext ? 25 : 13; m_ext = 0; m_ch = ch_sel;
        end else if (done) begin
          m_busy = 0; m_cyc = 0;
        end else if (rise && m_busy) m_cyc++;
        m_sc = nsc;
        if (rise) m_clk = 1; else if (fall) m_clk = 0;
        m_cnt = (m_cnt + 1) % 128;
      end
    end
  end

  always @(negedge clk) begin
    conv_v <= conv_v + 10'd37;
    cyc++;
    if (rst_n && !finished) begin
      chk(adc_clk == m_clk, "R1", "adc_clk", adc_clk, m_clk);
      chk(sample == m_samp, "R5", "sample", sample, m_samp);
      chk(flag == m_flag, "R10", "flag", flag, m_flag);
      chk(result == 10'(m_res), "R6", "result", result, m_res);
      chk(start == m_sc, "R7", "start", start, m_sc);
      chk(ch == 3'(m_ch), "R9", "ch", ch, m_ch);
    end
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_set = 1; tick(1); start_set = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; tick(1); flag_clr = 0;
  endtask

  // starts a conversion, counts adc_clk rises (launch edge included) until flag,
  // and the index of the falling edge carrying the sample strobe
  task automatic run_conv(output int rises, output int samp_at);
    bit prev;
    int falls, guard;
    pulse_start();
    prev = adc_clk; rises = 0; falls = 0; samp_at = 0; guard = 0;
    while (!flag && guard < 20000) begin
      tick(1); guard++;
      if (adc_clk && !prev) rises++;
      if (!adc_clk && prev && rises > 0) falls++;
      if (sample && samp_at == 0) samp_at = falls;
      prev = adc_clk;
    end
  endtask

  task automatic period(output int p);
    bit prev;
    int guard;
    prev = adc_clk; guard = 0;
    while (!(adc_clk && !prev) && guard < 1000) begin prev = adc_clk; tick(1); guard++; end
    p = 0; prev = adc_clk;
    do begin prev = adc_clk; tick(1); p++; end while (!(adc_clk && !prev) && p < 1000);
  endtask

  initial begin
    int r, s, held, p;
    tick(3);
    chk(adc_clk == 0 && start == 0 && flag == 0 && result == 0, "R2", "reset state",
        {adc_clk, start, flag, result}, 0);
    rst_n = 1;
    ps_sel = 2; en = 1; tick(3);
    run_conv(r, s);
    chk(r == 26, "R4", "extended rises", r, 26);
    chk(s == 14, "R5", "extended sample fall", s, 14);
    tick(2);
    chk(start == 0, "R7", "start after single", start, 0);
    tick(50);
    chk(flag == 1, "R10", "flag held", flag, 1);
    pulse_clr();
    chk(flag == 0, "R10", "flag cleared", flag, 0);
    run_conv(r, s);
    chk(r == 14, "R3", "normal rises", r, 14);
    chk(s == 2, "R5", "normal sample fall", s, 2);
    irq_ack = 1; tick(1); irq_ack = 0;
    chk(flag == 0, "R10", "flag ack", flag, 0);

    en = 0; tick(2); pulse_start(); tick(3);
    chk(start == 0, "R11", "start while off", start, 0);
    en = 1; tick(40);
    chk(flag == 0 && start == 0, "R11", "no conversion", flag, 0);

    ch_sel = 3; pulse_start(); tick(8); ch_sel = 5;
    while (!flag) tick(1);
    chk(ch == 3, "R9", "latched channel", ch, 3);
    pulse_clr();

    ps_sel = 0; free_run = 1; ch_sel = 1; pulse_start();
    for (int k = 0; k < 3; k++) begin
      while (!flag) tick(1);
      chk(start == 1, "R8", "start stays high", start, 1);
      pulse_clr();
      ch_sel = 3'(k + 2);
    end
    free_run = 0;
    while (!flag) tick(1);
    tick(2);
    chk(start == 0, "R7", "free off stops", start, 0);
    pulse_clr(); tick(100);
    chk(flag == 0, "R7", "no restart", flag, 0);

    ps_sel = 5; pulse_start(); tick(200);
    held = result; en = 0; tick(2);
    chk(start == 0 && adc_clk == 0, "R2", "abort idle", {start, adc_clk}, 0);
    tick(200);
    chk(result == 10'(held) && flag == 0, "R2", "abort keeps result", result, held);

    for (int sel = 0; sel < 8; sel++) begin
      ps_sel = 3'(sel); en = 1; tick(2);
      period(p);
      chk(p == ((sel < 2) ? 2 : (1 << sel)), "R1", "adc_clk period", p, (sel < 2) ? 2 : (1 << sel));
      en = 0; tick(2);
      chk(adc_clk == 0, "R2", "clk low when off", adc_clk, 0);
    end
    tick(5);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule